// File: doc/BRIEF.md
# Delayed Completion Discard Watchdog

This block watches a single delayed target transaction of a PCI bridge from the moment its slow backend cycle has finished until the original master comes back to collect the data. A backend-completion strobe arms a hold flag and a discard timer. The timer covers a one-millisecond window, computed from a clock-frequency parameter. If the master's return strobe arrives in time, the held data is handed over and the hold clears quietly. If it does not, the block drops the held completion and gives a one-cycle discard strobe.

Error reporting is separate from the discard. A timeout produces a one-cycle system-error request and latches a sticky status bit only when two enables are both set: a timeout-error enable and a global error enable. The status bit is cleared by software writing 1 to it. A separate path turns a one-clock low pulse on an active-low ECC interrupt line into a system-error request when its own enable is set.

The delayed mechanism lets slow backend cycles meet the 16-clock target response limit. The bus protocol engine that issues the retries lives outside this block.

Top module: `dly_txn_watch`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first cycle after it, `held`, `serr_req`, `discard` and `to_status` are all 0.
- R2: While `dt_en` is 0, `cmpl_done` is ignored and `held` stays 0 with no `discard`. Clearing `dt_en` while a transaction is held drops the hold on the next edge without a `discard` strobe.
- R3: A `cmpl_done` strobe with `dt_en` at 1 and nothing held sets `held` to 1 on the next clock edge.
- R4: Let W be CLK_HZ/1000 (at least 1). If the master does not return, `discard` is 1 for exactly one cycle following the W-th edge after the capture edge, and `held` falls on that same edge.
- R5: The discard on timeout happens whatever the values of `to_serr_en` and `serr_en`.
- R6: On a timeout, `serr_req` pulses and `to_status` becomes 1 only when both `to_serr_en` and `serr_en` are 1. If either is 0, neither happens.
- R7: A cycle with `stat_wr` at 1 and `stat_wdata` at 1 clears `to_status` on the next edge. A write with `stat_wdata` at 0 leaves it unchanged.
- R8: A `mst_return` strobe while held clears `held` on the next edge with no `discard` and no `serr_req`. This holds even when it arrives in the last cycle of the window.
- R9: With `ecc_serr_en` at 1, `ecc_int_n` low for exactly one cycle gives one `serr_req` cycle, two edges after the low sample. A low lasting two or more cycles, or `ecc_serr_en` at 0, gives none.
- R10: If a status-clear write and a reporting timeout fall in the same cycle, `to_status` ends up 1.
- R11: A `cmpl_done` strobe while a transaction is already held neither restarts nor extends the discard window.
- R12: `serr_req` is a single-cycle pulse for each event and is never raised without a reporting timeout or an enabled ECC pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dt_en | input | 1 | Delayed-transaction enable |
| to_serr_en | input | 1 | Enable for error reporting on timeout |
| serr_en | input | 1 | Global system-error enable |
| ecc_serr_en | input | 1 | Route one-clock ECC pulses to the system error |
| cmpl_done | input | 1 | Backend cycle of the held transaction has completed |
| mst_return | input | 1 | Original master has come back for the data |
| ecc_int_n | input | 1 | Active-low ECC interrupt, synchronous to clk |
| stat_wr | input | 1 | Write strobe for the status bit |
| stat_wdata | input | 1 | Write data; 1 clears the status bit |
| held | output | 1 | A completed delayed transaction is being held |
| serr_req | output | 1 | One-cycle system-error request |
| discard | output | 1 | One-cycle strobe: held completion dropped on timeout |
| to_status | output | 1 | Sticky timeout-error status, write-1-to-clear |

## Verification
The assertions assume that every input is synchronous to `clk` and free of X after reset. They also assume that `cmpl_done`, `mst_return` and `stat_wr` are single-cycle strobes from logic that follows the bus rules. The bench changes every input on the falling edge only, so the design always samples settled values. It raises each strobe for one cycle, and shapes ECC lows by whole cycles to obtain the one-cycle and longer cases.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int unsigned MS_DIV = 1000;

  // Cycles in the one-millisecond discard window, never below one.
  function automatic int unsigned win_cycles(input int unsigned hz);
    int unsigned c;
    c = hz / MS_DIV;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Counter width able to hold 0 .. n-1.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Timeout reporting needs both enables.
  function automatic logic report_gate(input logic local_en, input logic global_en);
    return local_en & global_en;
  endfunction

  // One-clock low pulse: high two samples ago, low one sample ago, high now.
  function automatic logic short_low(input logic older, input logic prev, input logic now);
    return older & ~prev & now;
  endfunction
endpackage

// File: rtl/dtw_hold_timer.sv
module dtw_hold_timer #(
  parameter int unsigned WIN = 33000,
  parameter int unsigned CW  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dt_en,
  input  logic cmpl_done,
  input  logic mst_return,
  output logic held,
  output logic expire
);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic          held_q;
  logic [CW-1:0] cnt_q;
  logic          capture_w;
  logic          handover_w;
  logic          at_last_w;

  assign capture_w  = dt_en && !held_q && cmpl_done;
  assign handover_w = dt_en && held_q && mst_return;
  assign at_last_w  = held_q && (cnt_q == LAST);
  assign expire     = dt_en && at_last_w && !mst_return;
  assign held       = held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!dt_en) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else if (capture_w) begin
      held_q <= 1'b1;
      cnt_q  <= '0;
    end else if (held_q) begin
      if (handover_w || expire) begin
        held_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R2
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dt_en |=> !held_q);

  // R4
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_q) |-> (!$past(dt_en) || $past(mst_return) || $past(cnt_q) == LAST));

  // R11
  window_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q && $past(held_q) |-> cnt_q == CW'($past(cnt_q) + CW'(1)));
endmodule

// File: rtl/dtw_ecc_detect.sv
module dtw_ecc_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ecc_int_n,
  output logic ecc_hit
);
  import dtw_pkg::*;

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= ecc_int_n;
      s2_q <= s1_q;
    end
  end

  assign ecc_hit = short_low(s2_q, s1_q, ecc_int_n);

  // R9
  ecc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_hit |=> !ecc_hit);
endmodule

// File: rtl/dtw_err_report.sv
module dtw_err_report (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic to_serr_en,
  input  logic serr_en,
  input  logic ecc_serr_en,
  input  logic ecc_hit,
  input  logic stat_wr,
  input  logic stat_wdata,
  output logic serr_req,
  output logic discard,
  output logic to_status
);
  import dtw_pkg::*;

  logic to_err_w;
  logic ecc_err_w;
  logic clr_w;
  logic serr_q;
  logic disc_q;
  logic stat_q;

  assign to_err_w  = expire && report_gate(to_serr_en, serr_en);
  assign ecc_err_w = ecc_hit && ecc_serr_en;
  assign clr_w     = stat_wr && stat_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serr_q <= 1'b0;
      disc_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      serr_q <= to_err_w || ecc_err_w;
      disc_q <= expire;
      if (to_err_w)   stat_q <= 1'b1;
      else if (clr_w) stat_q <= 1'b0;
    end
  end

  assign serr_req  = serr_q;
  assign discard   = disc_q;
  assign to_status = stat_q;

  // R6
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(to_serr_en && serr_en) && serr_q && disc_q);

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> $past(stat_wr && stat_wdata));

  // R12
  serr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_q |-> (disc_q || $past(ecc_hit && ecc_serr_en)));
endmodule

// File: rtl/dly_txn_watch.sv
module dly_txn_watch #(
  parameter int unsigned CLK_HZ = 33000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dt_en,
  input  logic to_serr_en,
  input  logic serr_en,
  input  logic ecc_serr_en,
  input  logic cmpl_done,
  input  logic mst_return,
  input  logic ecc_int_n,
  input  logic stat_wr,
  input  logic stat_wdata,
  output logic held,
  output logic serr_req,
  output logic discard,
  output logic to_status
);
  import dtw_pkg::*;

  localparam int unsigned WIN = win_cycles(CLK_HZ);
  localparam int unsigned CW  = cnt_bits(WIN);

  logic held_w;
  logic expire_w;
  logic ecc_hit_w;

  dtw_hold_timer #(.WIN(WIN), .CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .dt_en      (dt_en),
    .cmpl_done  (cmpl_done),
    .mst_return (mst_return),
    .held       (held_w),
    .expire     (expire_w)
  );

  dtw_ecc_detect u_ecc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_int_n (ecc_int_n),
    .ecc_hit   (ecc_hit_w)
  );

  dtw_err_report u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire      (expire_w),
    .to_serr_en  (to_serr_en),
    .serr_en     (serr_en),
    .ecc_serr_en (ecc_serr_en),
    .ecc_hit     (ecc_hit_w),
    .stat_wr     (stat_wr),
    .stat_wdata  (stat_wdata),
    .serr_req    (serr_req),
    .discard     (discard),
    .to_status   (to_status)
  );

  assign held = held_w;

  // R4
  discard_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> !held_w && $past(held_w));

  // R8
  return_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(held_w && mst_return && dt_en) |-> !discard && !held_w);

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dt_en && cmpl_done && !held_w) && dt_en |-> held_w);
endmodule

// File: tb/sim_dly_txn_watch.sv
module sim_dly_txn_watch;
  localparam int unsigned HZ = 8000;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, dt_en, to_serr_en, serr_en, ecc_serr_en;
  logic cmpl_done, mst_return, ecc_int_n, stat_wr, stat_wdata;
  logic held, serr_req, discard, to_status;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dly_txn_watch #(.CLK_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .dt_en(dt_en), .to_serr_en(to_serr_en),
    .serr_en(serr_en), .ecc_serr_en(ecc_serr_en), .cmpl_done(cmpl_done),
    .mst_return(mst_return), .ecc_int_n(ecc_int_n), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .held(held), .serr_req(serr_req),
    .discard(discard), .to_status(to_status)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_status();
    stat_wr = 1'b1; stat_wdata = 1'b1;
    step();
    stat_wr = 1'b0; stat_wdata = 1'b0;
  endtask

  // Leaves the time just after the capture edge.
  task automatic start_txn();
    cmpl_done = 1'b1;
    step();
    cmpl_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "held", held, 1'b0);
    chk("R1", "serr", serr_req, 1'b0);
    chk("R1", "discard", discard, 1'b0);
    chk("R1", "status", to_status, 1'b0);
  endtask

  task automatic t_disabled();
    logic seen;
    dt_en = 1'b0;
    start_txn();
    chk("R2", "held when disabled", held, 1'b0);
    seen = 1'b0;
    for (int k = 0; k < W + 3; k++) begin
      step();
      seen |= discard | held;
    end
    chk("R2", "activity when disabled", seen, 1'b0);
    dt_en = 1'b1;
    start_txn();
    step(); step();
    dt_en = 1'b0;
    step();
    chk("R2", "hold dropped on disable", held, 1'b0);
    seen = 1'b0;
    for (int k = 0; k < W + 2; k++) begin
      step();
      seen |= discard;
    end
    chk("R2", "no discard after disable", seen, 1'b0);
    dt_en = 1'b1;
  endtask

  task automatic t_timeout(input logic a, input logic b);
    to_serr_en = a; serr_en = b;
    clear_status();
    start_txn();
    chk("R3", "held after capture", held, 1'b1);
    for (int k = 1; k < W; k++) step();
    chk("R4", "no early discard", discard, 1'b0);
    chk("R4", "held before expiry", held, 1'b1);
    step();
    chk("R5", "discard on expiry", discard, 1'b1);
    chk("R4", "held cleared", held, 1'b0);
    chk("R6", "serr gated", serr_req, a & b);
    chk("R6", "status gated", to_status, a & b);
    step();
    chk("R4", "discard one cycle", discard, 1'b0);
    chk("R12", "serr one cycle", serr_req, 1'b0);
  endtask

  task automatic t_w1c();
    to_serr_en = 1'b1; serr_en = 1'b1;
    start_txn();
    for (int k = 0; k < W; k++) step();
    chk("R7", "status set", to_status, 1'b1);
    stat_wr = 1'b1; stat_wdata = 1'b0;
    step();
    stat_wr = 1'b0;
    chk("R7", "write 0 keeps status", to_status, 1'b1);
    clear_status();
    chk("R7", "write 1 clears status", to_status, 1'b0);
  endtask

  task automatic t_return(input int at);
    to_serr_en = 1'b1; serr_en = 1'b1;
    start_txn();
    for (int k = 0; k < at; k++) step();
    mst_return = 1'b1;
    step();
    mst_return = 1'b0;
    chk("R8", "held cleared by return", held, 1'b0);
    chk("R8", "no discard on return", discard, 1'b0);
    chk("R8", "no serr on return", serr_req, 1'b0);
    step();
    chk("R8", "no late discard", discard, 1'b0);
    chk("R8", "status untouched", to_status, 1'b0);
  endtask

  task automatic t_ecc();
    logic seen;
    ecc_serr_en = 1'b1;
    ecc_int_n = 1'b0;
    step();
    ecc_int_n = 1'b1;
    chk("R9", "no serr yet", serr_req, 1'b0);
    step();
    chk("R9", "ecc serr pulse", serr_req, 1'b1);
    step();
    chk("R12", "ecc serr one cycle", serr_req, 1'b0);
    chk("R9", "ecc does not set status", to_status, 1'b0);
    ecc_int_n = 1'b0;
    step(); step(); step();
    ecc_int_n = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 4; k++) begin step(); seen |= serr_req; end
    chk("R9", "long low ignored", seen, 1'b0);
    ecc_serr_en = 1'b0;
    ecc_int_n = 1'b0;
    step();
    ecc_int_n = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 4; k++) begin step(); seen |= serr_req; end
    chk("R9", "disabled ecc ignored", seen, 1'b0);
  endtask

  task automatic t_set_beats_clear();
    to_serr_en = 1'b1; serr_en = 1'b1;
    start_txn();
    for (int k = 1; k < W; k++) step();
    stat_wr = 1'b1; stat_wdata = 1'b1;
    step();
    stat_wr = 1'b0; stat_wdata = 1'b0;
    chk("R10", "set wins over clear", to_status, 1'b1);
    clear_status();
  endtask

  task automatic t_recapture();
    to_serr_en = 1'b0; serr_en = 1'b1;
    start_txn();
    step(); step();
    cmpl_done = 1'b1;
    step();
    cmpl_done = 1'b0;
    for (int k = 3; k < W; k++) step();
    chk("R11", "window not extended", discard, 1'b1);
    chk("R5", "discard with reporting off", held, 1'b0);
    step();
  endtask

  initial begin
    rst_n = 1'b0; dt_en = 1'b1; to_serr_en = 1'b0; serr_en = 1'b0;
    ecc_serr_en = 1'b0; cmpl_done = 1'b0; mst_return = 1'b0;
    ecc_int_n = 1'b1; stat_wr = 1'b0; stat_wdata = 1'b0;
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_disabled();
    t_timeout(1'b1, 1'b1);
    t_timeout(1'b0, 1'b1);
    t_timeout(1'b1, 1'b0);
    t_timeout(1'b0, 1'b0);
    t_w1c();
    t_return(2);
    t_return(W - 1);
    t_ecc();
    t_set_beats_clear();
    t_recapture();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule